// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Rank-Based Recency

This block caches virtual-to-physical page translations for a 16-bit virtual address space divided into 256-byte pages. Each request carries a virtual address and a write flag. The upper eight bits, the page number, are compared against every stored mapping at the same time. On a hit, the physical address comes back in the same cycle.

On a miss, the block takes the oldest frame from a small queue of free physical frames. It installs the new mapping at the next clock edge and reports the resulting physical address one cycle after the request. Recency is tracked as an explicit rank per entry, where 0 is the most recent. Empty slots are filled before any live mapping is evicted. When every slot is live, the entry holding the oldest rank is replaced.

A miss that arrives while the frame queue is empty is refused with a fault indication. The stored table is left untouched in that case.

Top module: `tlb_rank_lru`

## Requirements
- R1: After reset every entry is invalid. No virtual address hits, `fill_done` is 0, and with an empty frame queue every request raises `fault`.
- R2: A request whose page number matches a valid entry drives `hit`=1 in the same cycle. `hit_pa` is the entry's frame number in bits [15:8] and the request's unchanged low 8 bits in bits [7:0].
- R3: A miss with at least one queued frame drives `hit`=0. In the next cycle it drives `fill_done`=1 with `fill_pa` = {frame, request offset}. A later request to that page hits with the same frame.
- R4: The free-frame queue hands out frames in the order they were pushed. It holds at most 4 frames, and a push while 4 are held is dropped.
- R5: A miss with an empty frame queue drives `fault`=1 in the same cycle. No `fill_done` follows, and all stored mappings, ranks and dirty bits remain as they were.
- R6: A fill goes to the lowest-numbered invalid entry. When all 8 entries are valid, the fill replaces the entry with rank 7, the least recently used one.
- R7: An accessed entry (hit or fill) takes rank 0. Every entry with a rank below the accessed entry's old rank moves up by one, and the other ranks stay as they were.
- R8: A write hit sets the entry's dirty bit. On a hit, `hit_dirty` shows the dirty bit as it stood before that access.
- R9: A newly filled entry's dirty bit equals the write flag of the request that caused the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| free_push | input | 1 | Push `free_ppn` into the free-frame queue |
| free_ppn | input | 8 | Free physical frame number to queue |
| req_valid | input | 1 | Translation request present |
| req_va | input | 16 | Virtual address of the request |
| req_write | input | 1 | Request is a write |
| hit | output | 1 | Request hit a valid entry (same cycle) |
| hit_pa | output | 16 | Physical address on a hit, 0 otherwise |
| hit_dirty | output | 1 | Dirty bit of the hit entry before this access |
| fault | output | 1 | Miss refused because the frame queue is empty |
| fill_done | output | 1 | A fill was installed at the last clock edge |
| fill_pa | output | 16 | Physical address produced by that fill |

## Verification
Recency ranks, dirty bits and victim choice are internal, so a corrupted rank appears at the ports only on a later eviction. The wrong page survives and the page that should have survived misses, which can take several fills to show. The bench therefore drives long request streams over a page set larger than the table and checks every hit, fault and fill address against an arithmetic model. A lost dirty bit shows on the next hit to that page through `hit_dirty`. A frame-queue ordering fault shows on the very next fill through `fill_pa`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_HIT   = 2'd1,
      ACC_FILL  = 2'd2,
      ACC_FAULT = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/tlb_free_pool.sv
module tlb_free_pool #(
   parameter int PPN_W = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PPN_W-1:0] push_ppn,
   input  logic             pop,
   output logic [PPN_W-1:0] head_ppn,
   output logic             empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 1 && PPN_W >= 1) else $error("tlb_free_pool: bad parameters");

   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign do_push = push && (cnt_q != CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (do_push && !do_pop)
         cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push)
         cnt_q <= cnt_q - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [PPN_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (do_push) slot_q <= push_ppn;
         end
         assign head_ppn = slot_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [DEPTH-1:0][PPN_W-1:0] mem_q;
         logic [PTR_W-1:0]            rd_q, wr_q;

         function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q <= '0;
               wr_q <= '0;
            end else begin
               if (do_push) wr_q <= step(wr_q);
               if (do_pop)  rd_q <= step(rd_q);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem_q[wr_q] <= push_ppn;
         end

         assign head_ppn = mem_q[rd_q];
      end
   endgenerate

   a_r4_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));
   a_r4_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && cnt_q < CNT_W'(DEPTH)) |=> !empty);
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N     = 8,
   parameter int VPN_W = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0][VPN_W-1:0] tab_vpn,
   input  logic [N-1:0]            tab_valid,
   input  logic [VPN_W-1:0]        key,
   output logic [N-1:0]            match,
   output logic                    any,
   output logic [IDX_W-1:0]        idx
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign match[g] = tab_valid[g] && (tab_vpn[g] == key);
      end
   endgenerate

   assign any = |match;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
         if (match[i]) idx = idx | IDX_W'(i);
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]            valid,
   input  logic [N-1:0][IDX_W-1:0] rank,
   output logic [IDX_W-1:0]        victim
);
   logic found;

   always_comb begin
      victim = '0;
      found  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!valid[i] && !found) begin
            victim = IDX_W'(i);
            found  = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < N; i++)
            if (rank[i] == IDX_W'(N - 1)) victim = IDX_W'(i);
      end
   end
endmodule

// File: rtl/tlb_rank_lru.sv
module tlb_rank_lru
   import tlb_pkg::*;
#(
   parameter int VA_W       = 16,
   parameter int PAGE_BYTES = 256,
   parameter int ENTRIES    = 8,
   parameter int PPN_W      = 8,
   parameter int POOL_DEPTH = 4,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int PA_W      = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             free_push,
   input  logic [PPN_W-1:0] free_ppn,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   output logic             hit,
   output logic [PA_W-1:0]  hit_pa,
   output logic             hit_dirty,
   output logic             fault,
   output logic             fill_done,
   output logic [PA_W-1:0]  fill_pa
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int IDX_W = $clog2(ENTRIES);

   initial assert (ENTRIES >= 2 && VA_W > OFF_W && (1 << OFF_W) == PAGE_BYTES)
      else $error("tlb_rank_lru: bad parameters");

   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [ENTRIES-1:0][IDX_W-1:0] rank_q;
   logic [ENTRIES-1:0]            valid_q, dirty_q, match, at_max;

   logic [VPN_W-1:0] req_vpn;
   logic [OFF_W-1:0] req_off;
   logic [IDX_W-1:0] hit_idx, vic_idx, tgt, tgt_rank;
   logic             match_any, pool_empty, pool_pop;
   logic [PPN_W-1:0] pool_head;
   acc_kind_e        acc_kind;

   assign req_vpn = req_va[VA_W-1:OFF_W];
   assign req_off = req_va[OFF_W-1:0];

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
      .tab_vpn(vpn_q), .tab_valid(valid_q), .key(req_vpn),
      .match(match), .any(match_any), .idx(hit_idx));

   tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .valid(valid_q), .rank(rank_q), .victim(vic_idx));

   tlb_free_pool #(.PPN_W(PPN_W), .DEPTH(POOL_DEPTH)) u_pool (
      .clk(clk), .rst_n(rst_n), .push(free_push), .push_ppn(free_ppn),
      .pop(pool_pop), .head_ppn(pool_head), .empty(pool_empty));

   always_comb begin
      if (!req_valid)     acc_kind = ACC_NONE;
      else if (match_any) acc_kind = ACC_HIT;
      else if (pool_empty) acc_kind = ACC_FAULT;
      else                acc_kind = ACC_FILL;
   end

   assign tgt       = (acc_kind == ACC_HIT) ? hit_idx : vic_idx;
   assign tgt_rank  = rank_q[tgt];
   assign pool_pop  = (acc_kind == ACC_FILL);
   assign hit       = (acc_kind == ACC_HIT);
   assign hit_pa    = hit ? {ppn_q[hit_idx], req_off} : '0;
   assign hit_dirty = hit && dirty_q[hit_idx];
   assign fault     = (acc_kind == ACC_FAULT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i]   <= '0;
            ppn_q[i]   <= '0;
            valid_q[i] <= 1'b0;
            dirty_q[i] <= 1'b0;
            rank_q[i]  <= IDX_W'(ENTRIES - 1);
         end
      end else if (acc_kind == ACC_HIT || acc_kind == ACC_FILL) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == tgt) begin
               rank_q[i] <= '0;
               if (acc_kind == ACC_FILL) begin
                  vpn_q[i]   <= req_vpn;
                  ppn_q[i]   <= pool_head;
                  valid_q[i] <= 1'b1;
                  dirty_q[i] <= req_write;
               end else begin
                  dirty_q[i] <= dirty_q[i] | req_write;
               end
            end else if (rank_q[i] < tgt_rank) begin
               rank_q[i] <= rank_q[i] + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_done <= 1'b0;
         fill_pa   <= '0;
      end else begin
         fill_done <= (acc_kind == ACC_FILL);
         fill_pa   <= {pool_head, req_off};
      end
   end

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_oldest
         assign at_max[g] = (rank_q[g] == IDX_W'(ENTRIES - 1));
      end
   endgenerate

   a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   a_r3_fill_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit && !fault) |=> fill_done);
   a_r5_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fill_done);
   a_r5_fault_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> $stable(valid_q));
   a_r6_unique_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (&valid_q) |-> $onehot(at_max));
   a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit && !fault && !(&valid_q)) |=>
         ($countones(valid_q) == $past($countones(valid_q)) + 1));
   a_r7_target_rank0: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !fault) |=> (rank_q[$past(tgt)] == '0));
   a_r9_fill_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit && !fault) |=> (dirty_q[$past(vic_idx)] == $past(req_write)));
endmodule

// File: tb/tlb_rank_lru_tb.sv
`timescale 1ns/1ps
module tlb_rank_lru_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        free_push = 1'b0;
   logic [7:0]  free_ppn = '0;
   logic        req_valid = 1'b0;
   logic [15:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        hit, hit_dirty, fault, fill_done;
   logic [15:0] hit_pa, fill_pa;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0] m_vpn [8];
   logic [7:0] m_ppn [8];
   bit         m_valid [8];
   bit         m_dirty [8];
   int         m_rank [8];
   logic [7:0] m_pool [$];
   int unsigned lcg = 32'h1234_5678;

   always #2 clk = ~clk;

   tlb_rank_lru u_dut (
      .clk(clk), .rst_n(rst_n), .free_push(free_push), .free_ppn(free_ppn),
      .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
      .hit(hit), .hit_pa(hit_pa), .hit_dirty(hit_dirty), .fault(fault),
      .fill_done(fill_done), .fill_pa(fill_pa));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         m_vpn[i] = '0; m_ppn[i] = '0; m_valid[i] = 0; m_dirty[i] = 0; m_rank[i] = 7;
      end
      m_pool.delete();
   endtask

   task automatic push_frame(input logic [7:0] f);
      @(negedge clk);
      free_push = 1'b1; free_ppn = f;
      if (m_pool.size() < 4) m_pool.push_back(f);
      @(negedge clk);
      free_push = 1'b0;
   endtask

   function automatic int model_find(input logic [7:0] vpn);
      for (int i = 0; i < 8; i++)
         if (m_valid[i] && m_vpn[i] == vpn) return i;
      return -1;
   endfunction

   function automatic void model_touch(input int t);
      int old = m_rank[t];
      for (int i = 0; i < 8; i++)
         if (i != t && m_rank[i] < old) m_rank[i]++;
      m_rank[t] = 0;
   endfunction

   // Comb-only look: request present for under a half cycle, never sampled at an edge.
   task automatic probe(input logic [15:0] va, input string tag, input bit exp_hit);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = 1'b0;
      #1;
      chk(tag, hit, exp_hit);
      req_valid = 1'b0;
   endtask

   task automatic access(input logic [15:0] va, input bit wr);
      int h, v;
      bit exp_fault;
      logic [7:0] fr;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = wr;
      #1;
      h = model_find(va[15:8]);
      exp_fault = (h < 0) && (m_pool.size() == 0);
      chk("R2 hit flag", hit, h >= 0);
      if (h >= 0) begin
         chk("R2 hit_pa", hit_pa, {m_ppn[h], va[7:0]});
         chk("R8 hit_dirty", hit_dirty, m_dirty[h]);
      end
      chk("R5 fault flag", fault, exp_fault);
      fr = '0;
      if (h >= 0) begin
         model_touch(h);
         if (wr) m_dirty[h] = 1;
      end else if (!exp_fault) begin
         v = -1;
         for (int i = 0; i < 8; i++) if (v < 0 && !m_valid[i]) v = i;
         if (v < 0) for (int i = 0; i < 8; i++) if (m_rank[i] == 7) v = i;
         fr = m_pool.pop_front();
         model_touch(v);
         m_vpn[v] = va[15:8]; m_ppn[v] = fr; m_valid[v] = 1; m_dirty[v] = wr;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      chk("R3 fill_done", fill_done, (h < 0) && !exp_fault);
      if ((h < 0) && !exp_fault) chk("R3 R4 fill_pa", fill_pa, {fr, va[7:0]});
   endtask

   function automatic int unsigned rnd();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg >> 8;
   endfunction

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: empty table, empty queue
      chk("R1 fill_done idle", fill_done, 0);
      for (int p = 0; p < 256; p++) begin
         @(negedge clk);
         req_valid = 1'b1; req_va = {p[7:0], 8'h5a}; req_write = 1'b0;
         #1;
         chk("R1 no hit", hit, 0);
         chk("R1 fault", fault, 1);
         req_valid = 1'b0;
      end
      chk("R1 fill_done after sweep", fill_done, 0);

      // Three free frames, small scenario
      push_frame(8'h16); push_frame(8'h17); push_frame(8'h18);
      access(16'h0112, 1'b0);
      access(16'h01f0, 1'b1);      // R8 write hit
      access(16'h0134, 1'b0);      // R8 dirty now visible
      access(16'h2200, 1'b1);      // R9 fill as write
      access(16'h2201, 1'b0);
      access(16'h3377, 1'b0);
      access(16'h4400, 1'b0);      // R5 queue empty -> fault
      probe(16'h4400, "R5 faulted page still absent", 0);
      probe(16'h0100, "R5 earlier mapping intact", 1);

      // R4: overfill the queue, only four accepted
      for (int k = 0; k < 6; k++) push_frame(8'h80 + 8'(k));
      for (int k = 0; k < 5; k++) access({8'h50 + 8'(k), 8'h01}, 1'b0);

      // R6 R7: directed eviction order
      do_reset();
      for (int k = 0; k < 8; k++) begin
         if (m_pool.size() == 0) for (int j = 0; j < 4; j++) push_frame(8'(8'h20 + 8'(k) + 8'(j)));
         access({8'(k), 8'h00}, 1'b0);
      end
      access(16'h0000, 1'b0);      // page 0 becomes newest, page 1 oldest
      push_frame(8'hc0);
      access(16'h0800, 1'b0);      // evicts page 1
      probe(16'h0100, "R6 oldest entry evicted", 0);
      probe(16'h0000, "R7 touched entry kept", 1);
      probe(16'h0200, "R7 other entry kept", 1);

      // Long mixed stream over 12 pages with eviction and faults
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         int unsigned r = rnd();
         if (r % 5 == 0) push_frame(8'(rnd()));
         access({8'(r % 12), 8'(r >> 4)}, (r >> 12) % 3 == 0);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule